// File: doc/BRIEF.md
# Indexed Min-Heap Event Queue

This block keeps a set of scheduled events, one per reaction, ordered by their predicted time. Each entry pairs a 32-bit time key with a reaction index, and the entries sit in a binary min-heap. A second table maps every reaction index to the slot that currently holds it. Because of that table, the key of any reaction can be rewritten in place, not only the key at the root.

The queue is filled with load commands. Each load appends a new reaction, whose index is the current entry count, and then moves it up into place. After the load phase, update commands carry an index and a new key. The block finds the entry through the position table, writes the key, and restores heap order. It first tries to move the entry toward the root and, if that does not apply, moves it toward the smaller child. Each level takes one read, one compare and one swap cycle.

The root is always presented at the outputs: the smallest key and the reaction that owns it. Keys are compared as unsigned integers, which orders non-negative single-precision floats correctly. A reaction that should never fire is parked at +infinity (0x7F800000).

Top module: `pq_heap`

## Requirements
- R1: After reset, count is 0 and both busy and done are 0.
- R2: A load accepted while idle stores cmd_key for reaction index equal to count and increments count by one. A load issued when count already equals the capacity (2^IDX_W) is ignored: count does not change and busy stays low.
- R3: Whenever busy is low and count is non-zero, root_key is the smallest stored key and root_idx is a reaction whose stored key equals root_key.
- R4: An update (cmd_load=0) with cmd_idx below count replaces that reaction's key, wherever its entry sits in the heap. It leaves every other reaction's key unchanged.
- R5: An update whose cmd_idx is not below count is ignored: busy stays low and the root outputs do not change.
- R6: A command presented while busy is high is ignored, and it does not take effect later.
- R7: An accepted command keeps busy high for exactly 2 + 3*k cycles, where k is the number of levels the entry moves. A command whose entry does not move therefore keeps busy high for 2 cycles, and a single-level move keeps it high for 5 cycles.
- R8: Keys are ordered as unsigned 32-bit values. An entry at 0x7F800000 sorts after every finite positive key, and equal keys do not swap.
- R9: done is high for exactly one cycle, in the first cycle in which busy is low again after an accepted command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_load | input | 1 | 1 = append a new reaction, 0 = update an existing one |
| cmd_idx | input | IDX_W | Reaction index for an update |
| cmd_key | input | KEY_W | New time key |
| busy | output | 1 | Heap order is being restored; commands are ignored |
| done | output | 1 | One-cycle pulse when an accepted command has finished |
| count | output | IDX_W+1 | Number of loaded reactions |
| root_key | output | KEY_W | Smallest key in the heap |
| root_idx | output | IDX_W | Reaction index owning root_key |

## Verification
A command is accepted on a rising edge. From the next cycle busy is high for 2 + 3k cycles, and done is high in the first cycle after that. The bench drives commands at falling edges and samples at falling edges. It counts the busy cycles of every command and checks that the count leaves a remainder of 2 when divided by 3; it checks the exact count where k is known (0 or 1). The root outputs, count and done are read only at the first falling edge with busy low. For ignored commands, the bench reads busy one cycle after the command and checks that the root has not changed.

// File: rtl/pq_heap.sv
module pq_heap #(
  parameter int KEY_W = 32,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_load,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [KEY_W-1:0] cmd_key,
  output logic             busy,
  output logic             done,
  output logic [IDX_W:0]   count,
  output logic [KEY_W-1:0] root_key,
  output logic [IDX_W-1:0] root_idx
);
  localparam int DEPTH = 1 << IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_CMP, S_SWAP} st_t;
  typedef enum logic [1:0] {M_FIRST, M_UP, M_DOWN} mode_t;

  logic [KEY_W-1:0] key_mem [DEPTH];
  logic [IDX_W-1:0] idx_mem [DEPTH];
  logic [IDX_W-1:0] pos_mem [DEPTH];

  st_t              st;
  mode_t            mode;
  logic [IDX_W-1:0] cur, tgt;
  logic [KEY_W-1:0] k_cur, k_par, k_l, k_r, k_tgt;
  logic             has_l, has_r;

  wire [IDX_W+1:0] l_slot = {1'b0, cur, 1'b1};
  wire [IDX_W+1:0] r_slot = l_slot + 1'b1;
  wire [IDX_W-1:0] par    = (cur - 1'b1) >> 1;

  wire load_ok = count < (IDX_W+1)'(DEPTH);
  wire upd_ok  = {1'b0, cmd_idx} < count;
  wire accept  = cmd_valid && st == S_IDLE && (cmd_load ? load_ok : upd_ok);

  wire             pick_r = has_r && k_r < k_l;
  wire [KEY_W-1:0] k_min  = pick_r ? k_r : k_l;
  wire [IDX_W-1:0] c_slot = pick_r ? r_slot[IDX_W-1:0] : l_slot[IDX_W-1:0];
  wire up_ok   = mode != M_DOWN && cur != '0 && k_cur < k_par;
  wire down_ok = mode != M_UP && has_l && k_min < k_cur;

  assign busy     = st != S_IDLE;
  assign root_key = key_mem[0];
  assign root_idx = idx_mem[0];

  always_ff @(posedge clk) begin
    if (accept && cmd_load) begin
      key_mem[count[IDX_W-1:0]] <= cmd_key;
      idx_mem[count[IDX_W-1:0]] <= count[IDX_W-1:0];
      pos_mem[count[IDX_W-1:0]] <= count[IDX_W-1:0];
    end else if (accept) begin
      key_mem[pos_mem[cmd_idx]] <= cmd_key;
    end else if (st == S_SWAP) begin
      key_mem[cur] <= k_tgt;
      key_mem[tgt] <= k_cur;
      idx_mem[cur] <= idx_mem[tgt];
      idx_mem[tgt] <= idx_mem[cur];
      pos_mem[idx_mem[cur]] <= tgt;
      pos_mem[idx_mem[tgt]] <= cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      mode  <= M_FIRST;
      count <= '0;
      done  <= 1'b0;
      cur   <= '0;
      tgt   <= '0;
      k_cur <= '0;
      k_par <= '0;
      k_l   <= '0;
      k_r   <= '0;
      k_tgt <= '0;
      has_l <= 1'b0;
      has_r <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          mode <= M_FIRST;
          st   <= S_READ;
          if (cmd_load) begin
            cur   <= count[IDX_W-1:0];
            count <= count + 1'b1;
          end else begin
            cur <= pos_mem[cmd_idx];
          end
        end
        S_READ: begin
          k_cur <= key_mem[cur];
          k_par <= key_mem[par];
          k_l   <= key_mem[l_slot[IDX_W-1:0]];
          k_r   <= key_mem[r_slot[IDX_W-1:0]];
          has_l <= l_slot < (IDX_W+2)'(count);
          has_r <= r_slot < (IDX_W+2)'(count);
          st    <= S_CMP;
        end
        S_CMP: begin
          if (up_ok) begin
            tgt   <= par;
            k_tgt <= k_par;
            mode  <= M_UP;
            st    <= S_SWAP;
          end else if (down_ok) begin
            tgt   <= c_slot;
            k_tgt <= k_min;
            mode  <= M_DOWN;
            st    <= S_SWAP;
          end else begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_SWAP: begin
          cur <= tgt;
          st  <= S_READ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pq_heap_chk.sv
module pq_heap_chk #(
  parameter int KEY_W = 32,
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             busy,
  input logic             done,
  input logic [IDX_W:0]   count,
  input logic [KEY_W-1:0] root_key,
  input logic [KEY_W-1:0] k1,
  input logic [KEY_W-1:0] k2,
  input logic [IDX_W-1:0] pos_root
);
  assert_busy_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && busy |=> count == $past(count));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  assert_capacity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (IDX_W+1)'(1 << IDX_W));
  assert_root_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && count > 1 |-> root_key <= k1);
  assert_root_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && count > 2 |-> root_key <= k2);
  assert_pos_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && count > 0 |-> pos_root == '0);
endmodule

bind pq_heap pq_heap_chk #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .count(count), .root_key(root_key), .k1(key_mem[1]), .k2(key_mem[2]),
  .pos_root(pos_mem[idx_mem[0]])
);

// File: tb/pq_heap_bench.sv
module pq_heap_bench;
  localparam int KEY_W = 32;
  localparam int IDX_W = 10;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [31:0] INF = 32'h7F80_0000;
  localparam int NV = 13;
  // {load, idx, key, expected root_key, expected root_idx}
  localparam logic [84:0] VEC [NV] = '{
    {1'b1, 10'd0, 32'd50,   32'd50, 10'd0},
    {1'b1, 10'd0, 32'd30,   32'd30, 10'd1},
    {1'b1, 10'd0, 32'd70,   32'd30, 10'd1},
    {1'b1, 10'd0, 32'd10,   32'd10, 10'd3},
    {1'b1, 10'd0, 32'd90,   32'd10, 10'd3},
    {1'b1, 10'd0, 32'd20,   32'd10, 10'd3},
    {1'b0, 10'd3, 32'd100,  32'd20, 10'd5},
    {1'b0, 10'd5, INF,      32'd30, 10'd1},
    {1'b0, 10'd2, 32'd5,    32'd5,  10'd2},
    {1'b0, 10'd2, 32'd60,   32'd30, 10'd1},
    {1'b0, 10'd0, 32'd1,    32'd1,  10'd0},
    {1'b1, 10'd0, 32'd0,    32'd0,  10'd6},
    {1'b0, 10'd6, 32'h3F80_0000, 32'd1, 10'd0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_load = 1'b0;
  logic [IDX_W-1:0] cmd_idx = '0;
  logic [KEY_W-1:0] cmd_key = '0;
  logic             busy, done;
  logic [IDX_W:0]   count;
  logic [KEY_W-1:0] root_key;
  logic [IDX_W-1:0] root_idx;

  int checks = 0;
  int errors = 0;
  int cyc;

  pq_heap #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_pq_heap (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_load(cmd_load),
    .cmd_idx(cmd_idx), .cmd_key(cmd_key), .busy(busy), .done(done),
    .count(count), .root_key(root_key), .root_idx(root_idx)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input bit ld, input int idx, input logic [31:0] key, output int n);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_load = ld; cmd_idx = IDX_W'(idx); cmd_key = key;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    if (n > 0) chk(done == 1'b1, "R9 done at busy fall", done, 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [IDX_W:0] cnt_before;
    logic [31:0] rk;
    logic [9:0]  ri;
    do_reset();
    @(negedge clk);
    chk(count == 0, "R1 count", count, 0);
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);

    for (int v = 0; v < NV; v++) begin
      cnt_before = count;
      do_cmd(VEC[v][84], int'(VEC[v][83:74]), VEC[v][73:42], cyc);
      chk(cyc % 3 == 2, "R7 busy length", cyc, 2);
      chk(done == 1'b1, "R9 done", done, 1);
      if (VEC[v][84])
        chk(count == cnt_before + 1, "R2 load count", count, cnt_before + 1);
      chk(root_key == VEC[v][41:10], "R3/R4/R8 root key", root_key, VEC[v][41:10]);
      chk(root_idx == VEC[v][9:0], "R3/R4 root idx", root_idx, VEC[v][9:0]);
      @(negedge clk);
      chk(done == 1'b0, "R9 done one cycle", done, 0);
    end

    // R7: entry that stays put costs 2 busy cycles
    do_cmd(1'b0, 0, 32'd1, cyc);
    chk(cyc == 2, "R7 no-move latency", cyc, 2);
    // R8: equal key to root does not displace it
    do_cmd(1'b0, 4, 32'd1, cyc);
    chk(root_idx == 0, "R8 tie keeps root", root_idx, 0);
    do_cmd(1'b0, 4, 32'd90, cyc);

    // R5: update to an index not loaded
    rk = root_key; ri = root_idx;
    do_cmd(1'b0, 20, 32'd0, cyc);
    chk(cyc == 0, "R5 ignored busy", cyc, 0);
    chk(root_key == rk && root_idx == ri, "R5 root unchanged", root_key, rk);

    // R6: command while busy
    @(negedge clk);
    cmd_valid = 1'b1; cmd_load = 1'b0; cmd_idx = 10'd2; cmd_key = 32'd65;
    @(negedge clk);
    cmd_idx = 10'd6; cmd_key = 32'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R6 no late accept", busy, 0);
    chk(root_key == 32'd1 && root_idx == 0, "R6 root", root_key, 1);

    // R2/R7 full-capacity run
    do_reset();
    do_cmd(1'b1, 0, 32'd5, cyc);
    chk(cyc == 2, "R7 first load latency", cyc, 2);
    do_cmd(1'b1, 0, 32'd3, cyc);
    chk(cyc == 5, "R7 one-level latency", cyc, 5);
    for (int i = 2; i < DEPTH; i++) begin
      do_cmd(1'b1, 0, 32'(2000 - i), cyc);
      if (cyc % 3 != 2) chk(0, "R7 load length", cyc, 2);
    end
    chk(count == DEPTH, "R2 full count", count, DEPTH);
    chk(root_key == 3 && root_idx == 1, "R3 full root", root_key, 3);
    do_cmd(1'b1, 0, 32'd0, cyc);
    chk(cyc == 0 && count == DEPTH, "R2 load when full ignored", count, DEPTH);
    chk(root_key == 3, "R2 root after full load", root_key, 3);

    // R8/R4: park roots at +inf, remaining order must come out ascending
    for (int d = 0; d < 12; d++) begin
      do_cmd(1'b0, int'(root_idx), INF, cyc);
      if (d == 0) chk(root_key == 5 && root_idx == 0, "R8 drain", root_key, 5);
      else chk(root_key == 32'(976 + d) && root_idx == 10'(1024 - d),
               "R8 drain order", root_key, 976 + d);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule